// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block performs lane-parallel addition, subtraction and absolute value on a 64-bit word treated as a vector of equal-width lanes. A two-bit lane selector splits the word into eight 8-bit, four 16-bit or two 32-bit lanes. A three-bit operation selector picks one of these: wrapping add, wrapping subtract, unsigned saturating add, signed saturating add, unsigned saturating subtract, signed saturating subtract, or signed absolute value. Every lane is computed on its own. No carry, borrow or clamp crosses a lane boundary.

Not every operation exists at every lane width. Wrapping add and subtract work at all three widths. Unsigned saturating add exists only for 8-bit lanes. The other saturating operations and absolute value exist for 8-bit and 16-bit lanes. When a request names an operation and width that do not go together, the block returns an all-zero word and raises an illegal-operation flag.

The result passes through one output register. A request marked valid on one clock edge appears, with its valid bit, after that edge. The register keeps its last result while no request arrives.

Top module: `packed_addsub`

## Requirements
- R1: `lane_sel` encodes lane width as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. Lane 0 sits in the least significant bits, and no carry or borrow passes from one lane into the next.
- R2: `op_sel` 0 gives the lane sum modulo 2^W and `op_sel` 1 gives the lane difference a minus b modulo 2^W. Both are legal at all three widths.
- R3: `op_sel` 2 is an unsigned saturating add that clamps at the all-ones code. It is legal only with 8-bit lanes.
- R4: `op_sel` 3 is a signed saturating add on 8-bit or 16-bit lanes. It clamps to the two's-complement range of the lane.
- R5: `op_sel` 4 is an unsigned saturating subtract on 8-bit or 16-bit lanes. A lane yields 0 whenever a is smaller than b.
- R6: `op_sel` 5 is a signed saturating subtract on 8-bit or 16-bit lanes. It clamps to the signed range of the lane.
- R7: `op_sel` 6 gives the signed absolute value of each lane of `op_a` on 8-bit or 16-bit lanes. The most negative code (0x80 or 0x8000) maps to itself, and `op_b` has no effect on the result.
- R8: `op_sel` 7, `lane_sel` 3, `op_sel` 2 with 16-bit or 32-bit lanes, and `op_sel` 3 to 6 with 32-bit lanes each give `result` = 0 and `illegal_op` = 1. Every other combination gives `illegal_op` = 0.
- R9: A request with `in_valid` high shows up on `result` and `illegal_op` after the next rising edge, with `out_valid` high. After an edge with `in_valid` low, `out_valid` is 0 and `result` and `illegal_op` keep their values.
- R10: Reset is synchronous and active low. It clears `out_valid`, `result` and `illegal_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and selectors are valid this cycle |
| op_sel | input | 3 | Operation code (see R2 to R8) |
| lane_sel | input | 2 | Lane width code (see R1) |
| op_a | input | 64 | First operand, minuend, or absolute-value source |
| op_b | input | 64 | Second operand or subtrahend |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Registered packed result |
| illegal_op | output | 1 | Registered flag for an unsupported operation and width pair |

## Verification
Two things can meet at the output register in the same cycle. One is a new legal saturating or wrapping result. The other is the forced zero of an illegal combination, or the hold of an idle cycle. The bench provokes both by issuing back-to-back requests that alternate legal and illegal pairs, with idle gaps of random inputs placed between them. On every clock it compares all three outputs against a behavioural lane-by-lane model. Corner operands (0, all ones, the most negative code, the largest positive code) are mixed into random words, so saturation and absolute-value wrap are hit in some lanes while other lanes of the same word stay in range.

// File: rtl/packed_addsub_pkg.sv
// Shared encodings for the packed add/subtract unit.
package packed_addsub_pkg;

    // Operation codes presented on op_sel.
    typedef enum logic [2:0] {
        OP_ADD      = 3'd0,
        OP_SUB      = 3'd1,
        OP_ADDSAT_U = 3'd2,
        OP_ADDSAT_S = 3'd3,
        OP_SUBSAT_U = 3'd4,
        OP_SUBSAT_S = 3'd5,
        OP_ABS      = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    // Lane width codes presented on lane_sel.
    typedef enum logic [1:0] {
        LW_8    = 2'd0,
        LW_16   = 2'd1,
        LW_32   = 2'd2,
        LW_RSVD = 2'd3
    } lane_e;

endpackage

// File: rtl/packed_addsub_lane.sv
// One lane of width W: computes the selected add/subtract/abs result.
// Assumes legality was decided elsewhere; every code produces some value.
module packed_addsub_lane
    import packed_addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] UMAX = {W{1'b1}};
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   sum_x;
    logic [W:0]   dif_x;
    logic         add_sovf;
    logic         sub_sovf;
    logic [W-1:0] neg_a;

    assign sum_x = {1'b0, a} + {1'b0, b};
    assign dif_x = {1'b0, a} - {1'b0, b};
    assign neg_a = ~a + {{(W-1){1'b0}}, 1'b1};

    // Signed overflow: operands agree in sign (add) or differ (sub) and the result sign flips.
    assign add_sovf = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
    assign sub_sovf = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);

    // Result select per operation code.
    always_comb begin
        unique case (op)
            OP_ADD:      y = sum_x[W-1:0];
            OP_SUB:      y = dif_x[W-1:0];
            OP_ADDSAT_U: y = sum_x[W] ? UMAX : sum_x[W-1:0];
            OP_ADDSAT_S: y = add_sovf ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
            OP_SUBSAT_U: y = dif_x[W] ? '0 : dif_x[W-1:0];
            OP_SUBSAT_S: y = sub_sovf ? (a[W-1] ? SMIN : SMAX) : dif_x[W-1:0];
            OP_ABS:      y = a[W-1] ? neg_a : a;
            default:     y = '0;
        endcase
    end
endmodule

// File: rtl/packed_addsub_bank.sv
// A row of DATA_W/W independent lanes; lane 0 in the least significant bits.
// Assumes DATA_W is a multiple of W.
module packed_addsub_bank
    import packed_addsub_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int W      = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  op_e               op,
    output logic [DATA_W-1:0] y
);
    localparam int LANES = DATA_W / W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        packed_addsub_lane #(.W(W)) u_lane (
            .a  (a[i*W +: W]),
            .b  (b[i*W +: W]),
            .op (op),
            .y  (y[i*W +: W])
        );
    end
endmodule

// File: rtl/packed_addsub_decode.sv
// Decides whether an operation / lane width pair is supported.
// Assumes nothing beyond the package encodings.
module packed_addsub_decode
    import packed_addsub_pkg::*;
(
    input  op_e   op,
    input  lane_e lane,
    output logic  legal
);
    // Legality table by operation, then by width.
    always_comb begin
        if (lane == LW_RSVD) begin
            legal = 1'b0;
        end else begin
            unique case (op)
                OP_ADD, OP_SUB: legal = 1'b1;
                OP_ADDSAT_U:    legal = (lane == LW_8);
                OP_ADDSAT_S, OP_SUBSAT_U, OP_SUBSAT_S, OP_ABS:
                                legal = (lane != LW_32);
                default:        legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/packed_addsub.sv
// Packed add/subtract/abs unit with registered output and valid bit.
// Computes all three lane widths in parallel, selects one, zeroes illegal
// requests. Assumes DATA_W is a multiple of 32.
module packed_addsub
    import packed_addsub_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        lane_sel,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);
    op_e               op;
    lane_e             lane;
    logic              legal;
    logic [DATA_W-1:0] y8;
    logic [DATA_W-1:0] y16;
    logic [DATA_W-1:0] y32;
    logic [DATA_W-1:0] y_sel;
    logic [DATA_W-1:0] y_nxt;

    assign op   = op_e'(op_sel);
    assign lane = lane_e'(lane_sel);

    packed_addsub_decode u_dec (.op(op), .lane(lane), .legal(legal));

    packed_addsub_bank #(.DATA_W(DATA_W), .W(8))  u_b8  (.a(op_a), .b(op_b), .op(op), .y(y8));
    packed_addsub_bank #(.DATA_W(DATA_W), .W(16)) u_b16 (.a(op_a), .b(op_b), .op(op), .y(y16));
    packed_addsub_bank #(.DATA_W(DATA_W), .W(32)) u_b32 (.a(op_a), .b(op_b), .op(op), .y(y32));

    // Pick the bank that matches the requested width.
    always_comb begin
        unique case (lane)
            LW_8:    y_sel = y8;
            LW_16:   y_sel = y16;
            LW_32:   y_sel = y32;
            default: y_sel = '0;
        endcase
    end

    assign y_nxt = legal ? y_sel : '0;

    // Output register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            illegal_op <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= y_nxt;
                illegal_op <= ~legal;
            end
        end
    end
endmodule

// File: rtl/packed_addsub_chk.sv
// Property checker for packed_addsub, attached by bind below.
module packed_addsub_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic [1:0]        lane_sel,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              illegal_op
);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && !illegal_op));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(illegal_op)));

    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal_op) |-> result == '0);

    // R8
    reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 3'd7 || lane_sel == 2'd3)) |=> illegal_op);

    // R2
    wrap_add_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd0 && lane_sel == 2'd0)
        |=> result[7:0] == 8'($past(op_a[7:0]) + $past(op_b[7:0])));

    // R5
    usub_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd4 && lane_sel == 2'd0 && op_a[7:0] < op_b[7:0])
        |=> result[7:0] == 8'h00);
endmodule

bind packed_addsub packed_addsub_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .lane_sel(lane_sel), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .result(result), .illegal_op(illegal_op)
);

// File: tb/packed_addsub_bench.sv
module packed_addsub_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  lane_sel = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal_op;

    int          n_chk = 0;
    int          n_err = 0;
    logic        e_val = 1'b0;
    logic [63:0] e_res = '0;
    logic        e_ill = 1'b0;
    string       e_tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    packed_addsub u_packed_addsub (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .lane_sel(lane_sel), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .result(result), .illegal_op(illegal_op)
    );

    // Behavioural lane model: returns {illegal, result}.
    function automatic logic [64:0] model(logic [2:0] op, logic [1:0] ln,
                                          logic [63:0] a, logic [63:0] b);
        int w;
        longint m, ua, ub, sa, sb, r, smax, smin;
        logic [63:0] res;
        if (op == 3'd7 || ln == 2'd3 || (op == 3'd2 && ln != 2'd0) ||
            (op >= 3'd3 && ln == 2'd2))
            return {1'b1, 64'h0};
        w    = 8 << ln;
        m    = (64'sd1 <<< w) - 1;
        smax = (64'sd1 <<< (w-1)) - 1;
        smin = -(64'sd1 <<< (w-1));
        res  = '0;
        for (int i = 0; i < 64 / w; i++) begin
            ua = longint'(a >> (i*w)) & m;
            ub = longint'(b >> (i*w)) & m;
            sa = (ua > smax) ? ua - (m + 1) : ua;
            sb = (ub > smax) ? ub - (m + 1) : ub;
            case (op)
                3'd0: r = ua + ub;
                3'd1: r = ua - ub;
                3'd2: begin r = ua + ub; if (r > m) r = m; end
                3'd3: begin r = sa + sb; if (r > smax) r = smax; if (r < smin) r = smin; end
                3'd4: begin r = ua - ub; if (r < 0) r = 0; end
                3'd5: begin r = sa - sb; if (r > smax) r = smax; if (r < smin) r = smin; end
                default: r = (sa < 0) ? -sa : sa;
            endcase
            res = res | ((64'(r) & 64'(m)) << (i*w));
        end
        return {1'b0, res};
    endfunction

    task automatic compare();
        n_chk++;
        if (out_valid !== e_val || result !== e_res || illegal_op !== e_ill) begin
            n_err++;
            $display("FAIL %s: actual v=%b r=%h ill=%b expected v=%b r=%h ill=%b",
                     e_tag, out_valid, result, illegal_op, e_val, e_res, e_ill);
        end
    endtask

    // One clock: check outputs of the previous request, then drive the next.
    task automatic step(string tag, bit v, logic [2:0] op, logic [1:0] ln,
                        logic [63:0] a, logic [63:0] b);
        logic [64:0] m;
        @(negedge clk);
        compare();
        in_valid = v; op_sel = op; lane_sel = ln; op_a = a; op_b = b;
        e_tag = tag;
        e_val = v;
        if (v) begin
            m = model(op, ln, a, b);
            e_ill = m[64];
            e_res = m[63:0];
        end
    endtask

    function automatic logic [63:0] pick();
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            case ($urandom % 7)
                0: r[i*8 +: 8] = 8'h00;
                1: r[i*8 +: 8] = 8'hFF;
                2: r[i*8 +: 8] = 8'h80;
                3: r[i*8 +: 8] = 8'h7F;
                4: r[i*8 +: 8] = 8'h01;
                default: r[i*8 +: 8] = 8'($urandom);
            endcase
        end
        return r;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state is checked by the first step
        step("R1", 1, 3'd0, 2'd0, 64'h0000_0000_0000_00FF, 64'h1);
        step("R1", 1, 3'd0, 2'd1, 64'h0000_0000_0000_FFFF, 64'h1);
        step("R1", 1, 3'd0, 2'd2, 64'h0000_0000_FFFF_FFFF, 64'h1);
        step("R2", 1, 3'd1, 2'd0, 64'h0, 64'h0101_0101_0101_0101);
        step("R2", 1, 3'd1, 2'd2, 64'h0, 64'h1);
        step("R3", 1, 3'd2, 2'd0, 64'hFFFF_FF80_7F01_00FE, 64'h0102_8080_8001_FF01);
        step("R4", 1, 3'd3, 2'd0, 64'h7F80_7F80_0102_03FF, 64'h01FF_7F80_0102_0301);
        step("R4", 1, 3'd3, 2'd1, 64'h7FFF_8000_FFFF_0001, 64'h0001_FFFF_FFFF_7FFF);
        step("R5", 1, 3'd4, 2'd0, 64'h0001_0203_FF00_8080, 64'h0100_0302_00FF_7F81);
        step("R5", 1, 3'd4, 2'd1, 64'h0001_1234_FFFF_0000, 64'h0002_1234_0001_FFFF);
        step("R6", 1, 3'd5, 2'd0, 64'h807F_0000_7F80_1020, 64'h017F_807F_FF01_2010);
        step("R6", 1, 3'd5, 2'd1, 64'h8000_7FFF_0000_8000, 64'h0001_FFFF_8000_7FFF);
        step("R7", 1, 3'd6, 2'd0, 64'h8081_FF7F_0001_C040, 64'h0);
        step("R7", 1, 3'd6, 2'd0, 64'h8081_FF7F_0001_C040, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R7", 1, 3'd6, 2'd1, 64'h8000_8001_FFFF_7FFF, 64'h1234_5678_9ABC_DEF0);
        step("R8", 1, 3'd7, 2'd0, 64'hFFFF, 64'h1);
        step("R8", 1, 3'd0, 2'd3, 64'hFFFF, 64'h1);
        step("R8", 1, 3'd2, 2'd1, 64'hFFFF, 64'h1);
        step("R8", 1, 3'd5, 2'd2, 64'hFFFF, 64'h1);
        step("R9", 0, 3'd0, 2'd0, 64'h1234, 64'h5678);
        step("R9", 0, 3'd6, 2'd1, 64'h8000, 64'h0);
        step("R9", 1, 3'd0, 2'd0, 64'h1, 64'h1);
        step("R9", 0, 3'd7, 2'd3, 64'hFFFF, 64'hFFFF);
        // Random mix of legal and illegal pairs with idle gaps.
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] o;
            logic [1:0] l;
            o = 3'($urandom);
            l = 2'($urandom);
            case (o)
                3'd0, 3'd1: step("R2", 1'($urandom % 5 != 0), o, l, pick(), pick());
                3'd2: step("R3", 1'($urandom % 5 != 0), o, l, pick(), pick());
                3'd3: step("R4", 1'($urandom % 5 != 0), o, l, pick(), pick());
                3'd4: step("R5", 1'($urandom % 5 != 0), o, l, pick(), pick());
                3'd5: step("R6", 1'($urandom % 5 != 0), o, l, pick(), pick());
                3'd6: step("R7", 1'($urandom % 5 != 0), o, l, pick(), pick());
                default: step("R8", 1'($urandom % 5 != 0), o, l, pick(), pick());
            endcase
        end
        // Mid-run reset: R10
        step("R10", 1, 3'd0, 2'd0, 64'h5, 64'h6);
        @(negedge clk);
        compare();
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        e_tag = "R10"; e_val = 1'b0; e_res = '0; e_ill = 1'b0;
        step("R9", 0, 3'd0, 2'd0, 64'h0, 64'h0);
        step("R9", 0, 3'd0, 2'd0, 64'h0, 64'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule